// File: doc/BRIEF.md
# Tagged Random Read Request Generator

This block produces a stream of read requests at pseudo-random, access-aligned addresses. Each request carries a tag drawn from a pool of free tags. A request goes out only while the block is enabled and a free tag exists. This limits the number of reads in flight to the configured tag count.

Responses may arrive in any order. Each response names the tag of the request it answers. The block keeps the issued address of every tag in a table. When a response arrives, it looks the address up, presents it with a one-cycle strobe for a downstream write-back stage, and puts the tag back into the pool.

Software-style setup is reduced to two inputs: a tag count and a load pulse. The load is accepted only while the block is disabled. Addresses come from a Galois LFSR that steps once per accepted request.

Top module: `tagReadGen`

## Requirements
- R1: During and right after reset, `reqValid` and `doneValid` are low while `enable` is low. Reset fills the pool with all `NUM_TAGS` tags, 0 to `NUM_TAGS`-1, and seeds the LFSR with `LFSR_SEED` (default 32'h1).
- R2: `reqValid` is high exactly when `enable` is high and the pool holds at least one tag. With no free tag, no request is offered. A request is accepted in a cycle where `reqValid` and `reqReady` are both high.
- R3: `reqTag` is 11 bits wide, with the tag number zero-extended. No tag is issued twice while outstanding. After reset or a load, fresh tags go out in ascending order. After that, returned tags go out in the order they were returned.
- R4: In the cycle after a response is accepted (`rspValid` high), `doneValid` is high for one cycle. `doneAddr` then equals the `reqAddr` that was issued with the tag on `rspTag`, even when responses come out of order. `doneValid` is low in every other cycle.
- R5: A tag whose response is accepted in cycle c is back in the pool at the end of cycle c+1. It can therefore be offered again in cycle c+2 at the earliest.
- R6: The LFSR state s steps as s' = (s >> 1) XOR (s[0] ? 32'h80200003 : 0). It steps only on an accepted request. While a request is stalled, its address and tag do not change.
- R7: `reqAddr` = {s[ADDR_W-ALIGN_W-1:0], ALIGN_W zero bits}, so the low 4 address bits are always zero with the defaults.
- R8: A `cfgLoad` pulse while `enable` is low refills the pool with tags 0 to min(`cfgTagCount`, `NUM_TAGS`)-1. Any returned or pending tags are discarded. A count of 0 leaves the pool empty.
- R9: `cfgLoad` while `enable` is high is ignored, and the pool contents are unchanged.
- R10: Responses accepted while `enable` is low still produce their completion and return their tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows requests to be offered |
| cfgLoad | input | 1 | Load pulse for the tag count (used only while disabled) |
| cfgTagCount | input | $clog2(NUM_TAGS)+1 | Number of tags placed in the pool on load |
| reqValid | output | 1 | Read request offered |
| reqReady | input | 1 | Downstream accepts the request |
| reqTag | output | TAG_W (11) | Tag of the offered request |
| reqAddr | output | ADDR_W | Aligned pseudo-random read address |
| rspValid | input | 1 | A read response is present |
| rspTag | input | TAG_W (11) | Tag of the response |
| doneValid | output | 1 | One-cycle strobe for a completed read |
| doneAddr | output | ADDR_W | Original address of the completed read |

## Verification
The bench first issues a run of fresh tags with `reqReady` held high, then holds `reqReady` low. This separates an LFSR that steps per accepted request from one that runs freely. Responses to tags 4, 1 and 3 in that order test the tag-indexed lookup. They also show that returned tags queue behind the unused fresh ones.

A load of 3 tags exercises the empty pool. A response issued into that empty pool pins the exact cycle of tag reuse. A load pulse while enabled is then sent with two tags queued: honouring it would leave one tag, ignoring it leaves two. Loads of 0 and of an out-of-range count follow, and a long mixed phase varies the stall and response patterns.

// File: rtl/tagReadPkg.sv
package tagReadPkg;

  // Strobes from the pool control to the address datapath
  typedef struct packed {
    logic issue;   // request accepted this cycle: store address, step LFSR
    logic take;    // response accepted this cycle: look up address
  } tagStrobe_t;

  function automatic logic [31:0] galoisStep(input logic [31:0] s, input logic [31:0] taps);
    return (s >> 1) ^ (s[0] ? taps : 32'h0);
  endfunction

endpackage

// File: rtl/tagReadCtrl.sv
module tagReadCtrl
  import tagReadPkg::*;
#(
  parameter int NUM_TAGS = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        enable,
  input  logic                        cfgLoad,
  input  logic [$clog2(NUM_TAGS):0]   cfgTagCount,
  input  logic                        reqReady,
  input  logic                        rspValid,
  input  logic [$clog2(NUM_TAGS)-1:0] rspIdx,
  output logic                        reqValid,
  output logic [$clog2(NUM_TAGS)-1:0] headTag,
  output tagStrobe_t                  strobe
);
  localparam int IDX_W = $clog2(NUM_TAGS);
  localparam int CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_TAGS);

  // Fresh tags 0..limit-1 are handed out from a counter; returned tags
  // queue in a ring. Together they behave as a FIFO filled with 0..N-1.
  logic [CNT_W-1:0] freshNext, freshLimit, retCount;
  logic [IDX_W-1:0] retMem [NUM_TAGS];
  logic [IDX_W-1:0] wrPtr, rdPtr;
  logic             pendValid;
  logic [IDX_W-1:0] pendTag;

  logic freshAvail, retAvail, reload, pushRet, popRet;
  logic [CNT_W-1:0] loadLimit;

  assign freshAvail = freshNext < freshLimit;
  assign retAvail   = retCount != '0;
  assign headTag    = freshAvail ? freshNext[IDX_W-1:0] : retMem[rdPtr];
  assign reqValid   = enable && (freshAvail || retAvail);
  assign reload     = cfgLoad && !enable;
  assign loadLimit  = (cfgTagCount > FULL) ? FULL : cfgTagCount;

  assign strobe.issue = reqValid && reqReady;
  assign strobe.take  = rspValid;

  assign pushRet = pendValid && !reload;
  assign popRet  = strobe.issue && !freshAvail;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freshNext  <= '0;
      freshLimit <= FULL;
      retCount   <= '0;
      wrPtr      <= '0;
      rdPtr      <= '0;
      pendValid  <= 1'b0;
      pendTag    <= '0;
    end else if (reload) begin
      freshNext  <= '0;
      freshLimit <= loadLimit;
      retCount   <= '0;
      wrPtr      <= '0;
      rdPtr      <= '0;
      pendValid  <= 1'b0;
      pendTag    <= rspIdx;
    end else begin
      if (strobe.issue && freshAvail) freshNext <= freshNext + 1'b1;
      if (pushRet) begin
        retMem[wrPtr] <= pendTag;
        wrPtr         <= wrPtr + 1'b1;
      end
      if (popRet) rdPtr <= rdPtr + 1'b1;
      case ({pushRet, popRet})
        2'b10:   retCount <= retCount + 1'b1;
        2'b01:   retCount <= retCount - 1'b1;
        default: retCount <= retCount;
      endcase
      pendValid <= rspValid;
      pendTag   <= rspIdx;
    end
  end

endmodule

// File: rtl/tagReadDatapath.sv
module tagReadDatapath
  import tagReadPkg::*;
#(
  parameter int          NUM_TAGS  = 16,
  parameter int          ADDR_W    = 34,
  parameter int          ALIGN_W   = 4,
  parameter logic [31:0] LFSR_TAPS = 32'h80200003,
  parameter logic [31:0] LFSR_SEED = 32'h1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  tagStrobe_t                  strobe,
  input  logic [$clog2(NUM_TAGS)-1:0] headTag,
  input  logic [$clog2(NUM_TAGS)-1:0] rspIdx,
  output logic [ADDR_W-1:0]           reqAddr,
  output logic                        doneValid,
  output logic [ADDR_W-1:0]           doneAddr
);
  localparam int HI_W = ADDR_W - ALIGN_W;

  logic [31:0]     lfsr;
  logic [HI_W-1:0] addrTab [NUM_TAGS];
  logic [HI_W-1:0] doneHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsr      <= LFSR_SEED;
      doneValid <= 1'b0;
      doneHi    <= '0;
    end else begin
      if (strobe.issue) begin
        addrTab[headTag] <= lfsr[HI_W-1:0];
        lfsr             <= galoisStep(lfsr, LFSR_TAPS);
      end
      doneValid <= strobe.take;
      if (strobe.take) doneHi <= addrTab[rspIdx];
    end
  end

  generate
    if (ALIGN_W == 0) begin : g_noAlign
      assign reqAddr  = lfsr[HI_W-1:0];
      assign doneAddr = doneHi;
    end else begin : g_align
      assign reqAddr  = {lfsr[HI_W-1:0], {ALIGN_W{1'b0}}};
      assign doneAddr = {doneHi, {ALIGN_W{1'b0}}};
    end
    if (HI_W < 32) begin : g_lfsrSpare
      logic unusedLfsrHi;
      assign unusedLfsrHi = ^lfsr[31:HI_W];
    end
  endgenerate

endmodule

// File: rtl/tagReadGen.sv
module tagReadGen
  import tagReadPkg::*;
#(
  parameter int          NUM_TAGS  = 16,
  parameter int          TAG_W     = 11,
  parameter int          ADDR_W    = 34,
  parameter int          ALIGN_W   = 4,
  parameter logic [31:0] LFSR_TAPS = 32'h80200003,
  parameter logic [31:0] LFSR_SEED = 32'h1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      enable,
  input  logic                      cfgLoad,
  input  logic [$clog2(NUM_TAGS):0] cfgTagCount,
  output logic                      reqValid,
  input  logic                      reqReady,
  output logic [TAG_W-1:0]          reqTag,
  output logic [ADDR_W-1:0]         reqAddr,
  input  logic                      rspValid,
  input  logic [TAG_W-1:0]          rspTag,
  output logic                      doneValid,
  output logic [ADDR_W-1:0]         doneAddr
);
  localparam int IDX_W = $clog2(NUM_TAGS);

  tagStrobe_t       strobe;
  logic [IDX_W-1:0] headTag;
  logic [IDX_W-1:0] rspIdx;
  logic             unusedTagHi;

  assign rspIdx      = rspTag[IDX_W-1:0];
  assign unusedTagHi = ^rspTag[TAG_W-1:IDX_W];
  assign reqTag      = {{(TAG_W-IDX_W){1'b0}}, headTag};

  tagReadCtrl #(.NUM_TAGS(NUM_TAGS)) i_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgLoad(cfgLoad),
    .cfgTagCount(cfgTagCount), .reqReady(reqReady), .rspValid(rspValid),
    .rspIdx(rspIdx), .reqValid(reqValid), .headTag(headTag), .strobe(strobe)
  );

  tagReadDatapath #(
    .NUM_TAGS(NUM_TAGS), .ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W),
    .LFSR_TAPS(LFSR_TAPS), .LFSR_SEED(LFSR_SEED)
  ) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .headTag(headTag),
    .rspIdx(rspIdx), .reqAddr(reqAddr), .doneValid(doneValid),
    .doneAddr(doneAddr)
  );

endmodule

// File: rtl/tagReadGenChk.sv
module tagReadGenChk #(
  parameter int NUM_TAGS = 16,
  parameter int TAG_W    = 11,
  parameter int ADDR_W   = 34
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      enable,
  input logic                      cfgLoad,
  input logic [$clog2(NUM_TAGS):0] cfgTagCount,
  input logic                      reqValid,
  input logic                      reqReady,
  input logic [TAG_W-1:0]          reqTag,
  input logic [ADDR_W-1:0]         reqAddr,
  input logic                      rspValid,
  input logic [TAG_W-1:0]          rspTag,
  input logic                      doneValid
);
  localparam int IDX_W = $clog2(NUM_TAGS);
  localparam int CNT_W = IDX_W + 1;

  logic [NUM_TAGS-1:0] busy;
  logic [CNT_W-1:0]    outCnt, limit;
  logic                accept, unusedHi;
  logic [IDX_W-1:0]    reqIdx, rspIdx;

  assign accept   = reqValid && reqReady;
  assign reqIdx   = reqTag[IDX_W-1:0];
  assign rspIdx   = rspTag[IDX_W-1:0];
  assign unusedHi = ^{reqTag[TAG_W-1:IDX_W], rspTag[TAG_W-1:IDX_W]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= '0;
      outCnt <= '0;
      limit  <= CNT_W'(NUM_TAGS);
    end else if (cfgLoad && !enable) begin
      busy   <= '0;
      outCnt <= '0;
      limit  <= (cfgTagCount > CNT_W'(NUM_TAGS)) ? CNT_W'(NUM_TAGS) : cfgTagCount;
    end else begin
      if (accept) busy[reqIdx] <= 1'b1;
      if (rspValid && busy[rspIdx]) busy[rspIdx] <= 1'b0;
      outCnt <= outCnt + CNT_W'(accept) - CNT_W'(rspValid && busy[rspIdx]);
    end
  end

  // R2
  req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> enable);
  // R2
  pool_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    outCnt <= limit);
  // R3
  tag_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> !busy[reqIdx]);
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> doneValid);
  // R4
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |=> !doneValid);
  // R6
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (!enable || (reqValid && $stable(reqAddr) && $stable(reqTag))));

endmodule

bind tagReadGen tagReadGenChk #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .cfgLoad(cfgLoad),
  .cfgTagCount(cfgTagCount), .reqValid(reqValid), .reqReady(reqReady),
  .reqTag(reqTag), .reqAddr(reqAddr), .rspValid(rspValid), .rspTag(rspTag),
  .doneValid(doneValid)
);

// File: tb/test_tagReadGen.sv
module test_tagReadGen;
  localparam int NT = 16;
  localparam int TW = 11;
  localparam int AW = 34;

  logic          clk = 1'b0, rstN = 1'b0, enable = 1'b0, cfgLoad = 1'b0;
  logic [4:0]    cfgTagCount = '0;
  logic          reqReady = 1'b0, rspValid = 1'b0;
  logic [TW-1:0] rspTag = '0;
  logic          reqValid, doneValid;
  logic [TW-1:0] reqTag;
  logic [AW-1:0] reqAddr, doneAddr;

  tagReadGen i_tagReadGen (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgLoad(cfgLoad),
    .cfgTagCount(cfgTagCount), .reqValid(reqValid), .reqReady(reqReady),
    .reqTag(reqTag), .reqAddr(reqAddr), .rspValid(rspValid), .rspTag(rspTag),
    .doneValid(doneValid), .doneAddr(doneAddr)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  int poolQ[$];
  int outQ[$];
  logic [AW-1:0] doneQ[$];
  logic [AW-1:0] mAddr[NT];
  logic [31:0]   mLfsr = 32'h1;
  int  pend = -1;
  bit  expDone = 1'b0;
  bit  running = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'h80200003 : 32'h0);
  endfunction

  function automatic logic [AW-1:0] addrOf(input logic [31:0] s);
    return {s[29:0], 4'b0000};
  endfunction

  // driver: one clock cycle of stimulus plus expected-value bookkeeping
  task automatic step(input bit en, input bit rdy, input bit rv, input int rt,
                      input bit ld, input int cnt);
    bit expV, acc;
    int t;
    @(negedge clk);
    enable = en; reqReady = rdy; rspValid = rv; rspTag = TW'(rt);
    cfgLoad = ld; cfgTagCount = 5'(cnt);
    #1;
    expV = en && (poolQ.size() > 0);
    chk(reqValid == expV, "R2", "reqValid", reqValid, expV);
    chk(doneValid == expDone, "R4", "doneValid timing", doneValid, expDone);
    if (expV && reqValid) begin
      chk(reqTag == TW'(poolQ[0]), "R3", "reqTag", reqTag, poolQ[0]);
      chk(reqAddr == addrOf(mLfsr), "R6", "reqAddr", reqAddr, addrOf(mLfsr));
      chk(reqAddr[3:0] == 4'b0, "R7", "alignment", reqAddr[3:0], 0);
    end
    acc = expV && rdy;
    @(posedge clk);
    if (acc) begin
      t = poolQ.pop_front();
      mAddr[t] = addrOf(mLfsr);
      mLfsr = nxt(mLfsr);
      outQ.push_back(t);
    end
    if (ld && !en) begin
      poolQ.delete();
      for (int i = 0; i < ((cnt > NT) ? NT : cnt); i++) poolQ.push_back(i);
      pend = -1;
    end else begin
      if (pend >= 0) poolQ.push_back(pend);
      pend = rv ? rt : -1;
    end
    expDone = rv;
    if (rv) begin
      int idx[$];
      doneQ.push_back(mAddr[rt]);
      idx = outQ.find_first_index(x) with (x == rt);
      if (idx.size() > 0) outQ.delete(idx[0]);
    end
  endtask

  // monitor: compares completed addresses against the scoreboard
  always @(negedge clk) begin
    #2;
    if (running && doneValid) begin
      if (doneQ.size() == 0) chk(1'b0, "R4", "unexpected completion", doneAddr, 0);
      else begin
        logic [AW-1:0] e;
        e = doneQ.pop_front();
        chk(doneAddr == e, "R4", "doneAddr", doneAddr, e);
      end
    end
  end

  task automatic drain();
    while (outQ.size() > 0) step(0, 0, 1, outQ[outQ.size() / 2], 0, 0);
    step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 100000);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NT; i++) poolQ.push_back(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(reqValid == 1'b0, "R1", "reqValid in reset", reqValid, 0);
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk); #1;
    chk(reqValid == 1'b0, "R1", "reqValid after reset", reqValid, 0);
    chk(doneValid == 1'b0, "R1", "doneValid after reset", doneValid, 0);
    running = 1'b1;

    // R3 R6: fresh tags in ascending order with LFSR addresses
    repeat (6) step(1, 1, 0, 0, 0, 0);
    // R6: stalled request holds address, LFSR does not step
    repeat (3) step(1, 0, 0, 0, 0, 0);
    // R4: out-of-order responses
    step(1, 0, 1, 4, 0, 0);
    step(1, 0, 1, 1, 0, 0);
    step(1, 0, 1, 3, 0, 0);
    // R3: remaining fresh tags, then returned 4,1,3, then pool empty (R2)
    repeat (14) step(1, 1, 0, 0, 0, 0);
    // R10: responses while disabled still complete
    drain();

    // R8: load 3 tags
    step(0, 0, 0, 0, 1, 3);
    repeat (5) step(1, 1, 0, 0, 0, 0);
    // R5: tag 1 returned, unavailable next cycle, issued the one after
    step(1, 1, 1, 1, 0, 0);
    step(1, 1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0);
    // R9: load pulse while enabled is ignored
    step(1, 0, 1, 0, 0, 0);
    step(1, 0, 1, 2, 0, 0);
    step(1, 0, 0, 0, 1, 1);
    repeat (4) step(1, 1, 0, 0, 0, 0);
    drain();

    // R8: zero count leaves pool empty
    step(0, 0, 0, 0, 1, 0);
    repeat (3) step(1, 1, 0, 0, 0, 0);
    // R8: oversize count clamps to NUM_TAGS
    step(0, 0, 0, 0, 1, 31);
    for (int i = 0; i < 300; i++) begin
      bit rv;
      rv = (outQ.size() > 0) && (i % 2 == 0);
      step(1, (i % 3) != 0, rv, rv ? outQ[(i * 7) % outQ.size()] : 0, 0, 0);
    end
    drain();
    step(0, 0, 0, 0, 0, 0);
    chk(doneQ.size() == 0, "R4", "completions outstanding", doneQ.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule